// File: doc/BRIEF.md
# Trace token decompressor

This block turns a compressed trace byte stream back into the original per-channel 16-bit sample sequence. Each token starts with a 4-bit header nibble that names one of four coding modes and one of four channels. Tokens are packed back to back with no byte alignment. A full-value token therefore leaves the stream offset by half a byte, so the block works internally on a stream of nibbles.

For each channel the block keeps the last value, the last step between two samples, and a flag that the channel has been seeded by a full value. A full-value token or a small-step token produces one sample. A repeat-run token or a counter-run token expands into several samples over successive cycles. While a run expands, the byte input is held off. Samples leave one per handshake on a valid/ready output, tagged with their channel. A run token on an unseeded channel is dropped and flagged.

Top module: `tdc_trace_decomp`

## Requirements
- R1: Each byte is consumed high nibble first. A header nibble carries the mode in bits 3:2 (00 full value, 01 repeat run, 10 counter run, 11 small step) and the channel in bits 1:0. Tokens follow one another at nibble granularity with no byte alignment.
- R2: A full-value token is five nibbles long. The four nibbles after the header form the sample, most significant nibble first. That value is emitted, becomes the channel's last value, and marks the channel as seeded.
- R3: A small-step token carries one 4-bit two's complement nibble. It is sign-extended and added to the channel's last value modulo 2^16, and the sum is emitted and stored.
- R4: Every full-value or small-step sample sets the channel's stored step to the new value minus the previous value, modulo 2^16.
- R5: A repeat-run token with count N (its 4-bit second nibble) emits the channel's last value N times. N = 0 emits nothing.
- R6: A counter-run token with count N emits N samples, each equal to the previous one plus the stored step. The last one becomes the channel's value, and the stored step is left unchanged.
- R7: A run token for a channel that is not seeded pulses err_o high for exactly one cycle, emits no sample and leaves channel state untouched.
- R8: out_chan_o and out_sample_o stay stable while out_valid_o is high and out_ready_i is low. Exactly one sample is transferred per cycle in which both are high.
- R9: While a run is expanding, or while a token waits on a stalled output, byte_ready_o goes low once the internal nibble slots are full. No byte or nibble is lost or reordered.
- R10: After reset, out_valid_o and err_o are low and byte_ready_o is high. Every channel has value 0 and step 0 and is unseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Compressed stream byte |
| byte_valid_i | input | 1 | byte_i is valid |
| byte_ready_o | output | 1 | Block accepts byte_i this cycle |
| out_valid_o | output | 1 | Sample output is valid |
| out_ready_i | input | 1 | Consumer takes the sample this cycle |
| out_chan_o | output | 2 | Channel of the sample |
| out_sample_o | output | 16 | Rebuilt sample value |
| err_o | output | 1 | One-cycle pulse: run token on an unseeded channel |

## Verification
The last sample of a run can be handed off in the same cycle as the next token is taken from the parser, and the channel state written by that sample must then be seen by the following token. The bench provokes this with back-to-back run, small-step and full-value tokens, including tokens on the same channel, while out_ready_i follows an irregular pattern. It judges the result by comparing the complete ordered sample list against hand-computed values, so a dropped, duplicated or stale sample shows up at a known position. A separate stalled-output test confirms that the held sample stays stable, the byte input stalls, and the pending run then drains in order.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned CH_W  = 2;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned RUN_W = 4;

  typedef enum logic [1:0] {
    MODE_RAW    = 2'b00,
    MODE_VRUN   = 2'b01,
    MODE_DRUN   = 2'b10,
    MODE_SDELTA = 2'b11
  } mode_e;
endpackage

// File: rtl/tdc_nibble_feed.sv
module tdc_nibble_feed (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic [3:0] nib_o,
  output logic       nib_valid_o,
  input  logic       nib_ready_i
);
  logic [7:0] hold_q;
  logic [1:0] left_q;

  assign nib_valid_o  = left_q != 2'd0;
  assign nib_o        = left_q[1] ? hold_q[7:4] : hold_q[3:0];
  // refill as the last nibble leaves
  assign byte_ready_o = (left_q == 2'd0) || (left_q == 2'd1 && nib_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      left_q <= 2'd0;
    end else if (byte_valid_i && byte_ready_o) begin
      hold_q <= byte_i;
      left_q <= 2'd2;
    end else if (nib_valid_o && nib_ready_i) begin
      left_q <= left_q - 2'd1;
    end
  end
endmodule

// File: rtl/tdc_token_parser.sv
module tdc_token_parser
  import tdc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NIB_W-1:0]    nib_i,
  input  logic                nib_valid_i,
  output logic                nib_ready_o,
  output logic                tok_valid_o,
  output mode_e               tok_mode_o,
  output logic [CH_W-1:0]     tok_chan_o,
  output logic [SAMPLE_W-1:0] tok_data_o,
  input  logic                tok_ready_i
);
  localparam int unsigned RAW_NIBS = SAMPLE_W / NIB_W;
  localparam int unsigned CNT_W    = $clog2(RAW_NIBS + 1);
  localparam int unsigned ACC_W    = SAMPLE_W - NIB_W;

  logic              busy_q;
  mode_e             mode_q;
  logic [CH_W-1:0]   chan_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  need;
  logic              fire, last;

  assign need        = (mode_q == MODE_RAW) ? CNT_W'(RAW_NIBS) : CNT_W'(1);
  assign nib_ready_o = !tok_valid_o || tok_ready_i;
  assign fire        = nib_valid_i && nib_ready_o;
  assign last        = busy_q && (cnt_q + CNT_W'(1) == need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      mode_q      <= MODE_RAW;
      chan_q      <= '0;
      cnt_q       <= '0;
      acc_q       <= '0;
      tok_valid_o <= 1'b0;
      tok_mode_o  <= MODE_RAW;
      tok_chan_o  <= '0;
      tok_data_o  <= '0;
    end else begin
      if (tok_valid_o && tok_ready_i) tok_valid_o <= 1'b0;
      if (fire) begin
        if (!busy_q) begin
          busy_q <= 1'b1;
          mode_q <= mode_e'(nib_i[3:2]);
          chan_q <= nib_i[1:0];
          cnt_q  <= '0;
          acc_q  <= '0;
        end else if (last) begin
          busy_q      <= 1'b0;
          tok_valid_o <= 1'b1;
          tok_mode_o  <= mode_q;
          tok_chan_o  <= chan_q;
          tok_data_o  <= {acc_q, nib_i};
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          acc_q <= {acc_q[ACC_W-NIB_W-1:0], nib_i};
        end
      end
    end
  end

  // R9: a finished token is never overwritten before it is taken
  p_tok_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_o && !tok_ready_i |=> tok_valid_o && $stable(tok_data_o) && $stable(tok_chan_o));
endmodule

// File: rtl/tdc_chan_state.sv
module tdc_chan_state #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CH_W     = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CH_W-1:0]     rchan_i,
  output logic [SAMPLE_W-1:0] rval_o,
  output logic [SAMPLE_W-1:0] rdelta_o,
  output logic                rseen_o,
  input  logic                we_i,
  input  logic                wseed_i,
  input  logic [CH_W-1:0]     wchan_i,
  input  logic [SAMPLE_W-1:0] wval_i,
  input  logic [SAMPLE_W-1:0] wdelta_i
);
  localparam int unsigned NCH = 1 << CH_W;

  logic [SAMPLE_W-1:0] val_q   [NCH];
  logic [SAMPLE_W-1:0] delta_q [NCH];
  logic                seen_q  [NCH];
  logic [NCH-1:0]      seen_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[c]   <= '0;
        delta_q[c] <= '0;
        seen_q[c]  <= 1'b0;
      end else if (we_i && wchan_i == CH_W'(c)) begin
        val_q[c]   <= wval_i;
        delta_q[c] <= wdelta_i;
        if (wseed_i) seen_q[c] <= 1'b1;
      end
    end
    assign seen_vec[c] = seen_q[c];
  end

  assign rval_o   = val_q[rchan_i];
  assign rdelta_o = delta_q[rchan_i];
  assign rseen_o  = seen_q[rchan_i];

  // R2: seeding is sticky until reset
  p_seen_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (seen_vec & $past(seen_vec)) == $past(seen_vec));
endmodule

// File: rtl/tdc_expander.sv
module tdc_expander
  import tdc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tok_valid_i,
  input  mode_e               tok_mode_i,
  input  logic [CH_W-1:0]     tok_chan_i,
  input  logic [SAMPLE_W-1:0] tok_data_i,
  output logic                tok_ready_o,
  output logic [CH_W-1:0]     rchan_o,
  input  logic [SAMPLE_W-1:0] rval_i,
  input  logic [SAMPLE_W-1:0] rdelta_i,
  input  logic                rseen_i,
  output logic                we_o,
  output logic                wseed_o,
  output logic [SAMPLE_W-1:0] wval_o,
  output logic [SAMPLE_W-1:0] wdelta_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [CH_W-1:0]     out_chan_o,
  output logic [SAMPLE_W-1:0] out_sample_o,
  output logic                err_o
);
  logic [RUN_W-1:0]    rem_q;
  logic [CH_W-1:0]     run_chan_q;
  logic                run_delta_q;
  logic                slot, take, load, start_run, err_d;
  logic [SAMPLE_W-1:0] nxt, sd_ext;
  logic [RUN_W-1:0]    count;

  assign slot        = !out_valid_o || out_ready_i;
  assign tok_ready_o = (rem_q == '0) && slot;
  assign take        = tok_valid_i && tok_ready_o;
  assign rchan_o     = (rem_q != '0) ? run_chan_q : tok_chan_i;
  assign count       = tok_data_i[RUN_W-1:0];
  assign sd_ext      = {{(SAMPLE_W-NIB_W){tok_data_i[NIB_W-1]}}, tok_data_i[NIB_W-1:0]};

  always_comb begin
    we_o      = 1'b0;
    wseed_o   = 1'b0;
    wval_o    = rval_i;
    wdelta_o  = rdelta_i;
    load      = 1'b0;
    nxt       = rval_i;
    start_run = 1'b0;
    err_d     = 1'b0;
    if (rem_q != '0) begin
      if (slot) begin
        nxt    = run_delta_q ? rval_i + rdelta_i : rval_i;
        load   = 1'b1;
        we_o   = 1'b1;
        wval_o = nxt;
      end
    end else if (take) begin
      case (tok_mode_i)
        MODE_RAW, MODE_SDELTA: begin
          nxt      = (tok_mode_i == MODE_RAW) ? tok_data_i : rval_i + sd_ext;
          load     = 1'b1;
          we_o     = 1'b1;
          wseed_o  = (tok_mode_i == MODE_RAW);
          wval_o   = nxt;
          wdelta_o = nxt - rval_i;
        end
        default: begin
          if (!rseen_i) begin
            err_d = 1'b1;
          end else if (count != '0) begin
            nxt       = (tok_mode_i == MODE_DRUN) ? rval_i + rdelta_i : rval_i;
            load      = 1'b1;
            we_o      = 1'b1;
            wval_o    = nxt;
            start_run = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q        <= '0;
      run_chan_q   <= '0;
      run_delta_q  <= 1'b0;
      out_valid_o  <= 1'b0;
      out_chan_o   <= '0;
      out_sample_o <= '0;
      err_o        <= 1'b0;
    end else begin
      err_o <= err_d;
      if (load) begin
        out_valid_o  <= 1'b1;
        out_chan_o   <= rchan_o;
        out_sample_o <= nxt;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
      if (start_run) begin
        rem_q       <= count - RUN_W'(1);
        run_chan_q  <= tok_chan_i;
        run_delta_q <= (tok_mode_i == MODE_DRUN);
      end else if (rem_q != '0 && slot) begin
        rem_q <= rem_q - RUN_W'(1);
      end
    end
  end

  // R8: a stalled sample is held
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_sample_o) && $stable(out_chan_o));
  // R5: while samples of a run are pending, one is always on offer
  p_run_has_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q != '0 |-> out_valid_o);
  // R7: error is a single-cycle pulse
  p_err_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

// File: rtl/tdc_trace_decomp.sv
module tdc_trace_decomp
  import tdc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [7:0]          byte_i,
  input  logic                byte_valid_i,
  output logic                byte_ready_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [CH_W-1:0]     out_chan_o,
  output logic [SAMPLE_W-1:0] out_sample_o,
  output logic                err_o
);
  logic [NIB_W-1:0]    nib;
  logic                nib_valid, nib_ready;
  logic                tok_valid, tok_ready;
  mode_e               tok_mode;
  logic [CH_W-1:0]     tok_chan;
  logic [SAMPLE_W-1:0] tok_data;
  logic [CH_W-1:0]     rchan;
  logic [SAMPLE_W-1:0] rval, rdelta, wval, wdelta;
  logic                rseen, we, wseed;

  tdc_nibble_feed u_feed (
    .clk_i, .rst_ni, .byte_i, .byte_valid_i, .byte_ready_o,
    .nib_o(nib), .nib_valid_o(nib_valid), .nib_ready_i(nib_ready)
  );

  tdc_token_parser #(.SAMPLE_W(SAMPLE_W)) u_parser (
    .clk_i, .rst_ni,
    .nib_i(nib), .nib_valid_i(nib_valid), .nib_ready_o(nib_ready),
    .tok_valid_o(tok_valid), .tok_mode_o(tok_mode), .tok_chan_o(tok_chan),
    .tok_data_o(tok_data), .tok_ready_i(tok_ready)
  );

  tdc_chan_state #(.SAMPLE_W(SAMPLE_W), .CH_W(CH_W)) u_state (
    .clk_i, .rst_ni,
    .rchan_i(rchan), .rval_o(rval), .rdelta_o(rdelta), .rseen_o(rseen),
    .we_i(we), .wseed_i(wseed), .wchan_i(rchan), .wval_i(wval), .wdelta_i(wdelta)
  );

  tdc_expander #(.SAMPLE_W(SAMPLE_W)) u_exp (
    .clk_i, .rst_ni,
    .tok_valid_i(tok_valid), .tok_mode_i(tok_mode), .tok_chan_i(tok_chan),
    .tok_data_i(tok_data), .tok_ready_o(tok_ready),
    .rchan_o(rchan), .rval_i(rval), .rdelta_i(rdelta), .rseen_i(rseen),
    .we_o(we), .wseed_o(wseed), .wval_o(wval), .wdelta_o(wdelta),
    .out_valid_o, .out_ready_i, .out_chan_o, .out_sample_o, .err_o
  );
endmodule

// File: tb/tdc_trace_decomp_tb.sv
`timescale 1ns/1ps
module tdc_trace_decomp_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_ready_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [1:0]  out_chan_o;
  logic [15:0] out_sample_o;
  logic        err_o;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, n_got = 0, err_seen = 0;
  int rdy_mode = 0;
  logic [17:0] got [64];

  // nibble stream: 0 1234 | 4 3 | D E | 9 2 | 1 00F0 | 9 2 | C 7 | 8 2 | 5 0 | 2 FFFF | E 1 | 7 1 | A F | 5 1 | 3 ABCD
  localparam logic [7:0] STIM [21] = '{
    8'h01, 8'h23, 8'h44, 8'h3D, 8'hE9, 8'h21, 8'h00, 8'hF0, 8'h92, 8'hC7, 8'h82,
    8'h50, 8'h2F, 8'hFF, 8'hFE, 8'h17, 8'h1A, 8'hF5, 8'h13, 8'hAB, 8'hCD};
  localparam logic [17:0] EXP [30] = '{
    {2'd0,16'h1234}, {2'd0,16'h1234}, {2'd0,16'h1234}, {2'd0,16'h1234},
    {2'd1,16'hFFFE}, {2'd1,16'h00F0}, {2'd1,16'h01E2}, {2'd1,16'h02D4},
    {2'd0,16'h123B}, {2'd0,16'h1242}, {2'd0,16'h1249},
    {2'd2,16'hFFFF}, {2'd2,16'h0000},
    {2'd2,16'h0001}, {2'd2,16'h0002}, {2'd2,16'h0003}, {2'd2,16'h0004}, {2'd2,16'h0005},
    {2'd2,16'h0006}, {2'd2,16'h0007}, {2'd2,16'h0008}, {2'd2,16'h0009}, {2'd2,16'h000A},
    {2'd2,16'h000B}, {2'd2,16'h000C}, {2'd2,16'h000D}, {2'd2,16'h000E}, {2'd2,16'h000F},
    {2'd1,16'h02D4}, {2'd3,16'hABCD}};
  // requirement judged by each expected sample (R2 full, R3 step, R4 step update, R5 repeat, R6 counter, R1 unaligned)
  localparam int EXP_REQ [30] = '{2, 5, 5, 5, 3, 2, 4, 6, 3, 6, 6, 2, 3,
    6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 6, 5, 1};

  tdc_trace_decomp u_dut (
    .clk_i(clk), .rst_ni, .byte_i, .byte_valid_i, .byte_ready_o,
    .out_valid_o, .out_ready_i, .out_chan_o, .out_sample_o, .err_o
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    out_ready_i = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
    #1;
    if (rst_ni) begin
      if (err_o) err_seen++;
      if (out_valid_o && out_ready_i && n_got < 64) begin
        got[n_got] = {out_chan_o, out_sample_o};
        n_got++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    byte_valid_i = 1'b1;
    byte_i = b;
    #2;
    while (!byte_ready_o) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    byte_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_got(input int target, input int limit);
    for (int k = 0; k < limit && n_got < target; k++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base, ebase;
    // R10 reset state
    rdy_mode = 0;
    do_reset();
    #2;
    chk("R10", "byte_ready after reset", 32'(byte_ready_o), 32'd1);
    chk("R10", "out_valid after reset", 32'(out_valid_o), 32'd0);
    chk("R10", "err after reset", 32'(err_o), 32'd0);

    // mixed stream under irregular output readiness
    rdy_mode = 1;
    for (int i = 0; i < 21; i++) send_byte(STIM[i]);
    wait_got(30, 2000);
    chk("R5", "sample count (zero-length run emits none)", 32'(n_got), 32'd30);
    chk("R7", "error pulses on unseeded runs", 32'(err_seen), 32'd2);
    for (int i = 0; i < 30; i++)
      chk($sformatf("R%0d", EXP_REQ[i]), $sformatf("sample %0d", i), 32'(got[i]), 32'(EXP[i]));

    // R8 and R9: stalled output, run pending
    do_reset();
    rdy_mode = 2;
    base = n_got;
    send_byte(8'h00);
    send_byte(8'h00);
    send_byte(8'h54);
    send_byte(8'h2C);
    repeat (3) @(negedge clk);
    #2;
    chk("R2", "stalled sample value", 32'({out_valid_o, out_chan_o, out_sample_o}), 32'({1'b1, 2'd0, 16'h0005}));
    chk("R9", "byte input held during stall", 32'(byte_ready_o), 32'd0);
    repeat (5) @(negedge clk);
    #2;
    chk("R8", "sample stable under stall", 32'({out_valid_o, out_chan_o, out_sample_o}), 32'({1'b1, 2'd0, 16'h0005}));
    rdy_mode = 0;
    wait_got(base + 3, 100);
    chk("R8", "one sample per handshake", 32'(n_got - base), 32'd3);
    chk("R5", "repeat run samples", 32'({got[base+1], got[base+2][15:0]}), 32'({2'd0, 16'h0005, 16'h0005}));
    #2;
    chk("R9", "byte input reopened", 32'(byte_ready_o), 32'd1);
    base = n_got;
    send_byte(8'h3F);
    wait_got(base + 1, 100);
    chk("R3", "step token split over bytes", 32'(n_got - base), 32'd1);
    chk("R3", "step token value", 32'(got[base]), 32'({2'd0, 16'h0008}));

    // R10 and R7: reset clears seeding
    do_reset();
    base = n_got;
    ebase = err_seen;
    send_byte(8'h41);
    repeat (12) @(negedge clk);
    chk("R7", "run after reset flags error", 32'(err_seen - ebase), 32'd1);
    chk("R10", "no sample after reset run", 32'(n_got - base), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule